// File: doc/BRIEF.md
# Banked Register File With Sub-word Access

This block is the general-purpose register storage of a small processor core. It holds sixteen 32-bit registers arranged as four banks of four, plus four 32-bit registers outside the banking scheme. The last of those four fixed registers is the stack pointer. Any register can be read or written as a full word, as one of its two 16-bit halves, or as one of its four bytes. Sub-word reads come back zero-extended on a 32-bit bus. Sub-word writes merge into the register and leave the other bytes untouched.

A 16-bit status word holds the flag byte in bits [7:0] and the current bank number in bits [9:8]. An access names its register in one of two ways. A compact 3-bit code reaches the four registers of the current bank and the four fixed registers. An 8-bit extended code can reach every register and every byte lane, through the current bank, the previous bank, a bank given by number, or the fixed set. Two extra controls swap values with shadow copies. One exchanges the flag byte with a shadow flag byte. The other exchanges the accumulator byte (byte 0 of register 0 in the current bank) with a shadow accumulator byte.

The block has two combinational read ports and one write port. It is meant to sit beside an ALU and a decoder that produce the register codes. No state machine is present: the block has no sequencing of its own.

Top module: `bankreg_file`

## Requirements
- R1: After reset, every register, the status word, the shadow flag byte and the shadow accumulator byte are zero.
- R2: With the extended flag low, the 3-bit code in bits [2:0] selects a register at byte lane 0. Values 0–3 select registers 0–3 of the current bank, and values 4–7 select fixed registers 0–3.
- R3: With the extended flag high, the 8-bit code is split into four fields. Bits [7:6] give the mode: 00 = current bank, 01 = previous bank, 10 = bank number in bits [5:4], 11 = fixed set. Bits [3:2] give the register and bits [1:0] give the byte lane.
- R4: The current bank is status bits [9:8]. The previous bank is (current − 1) mod 4, so bank 0 wraps to bank 3.
- R5: The size code is 00 for a byte (at the lane given), 01 for a half (lane bit 1 picks the half, lane bit 0 is ignored), and 10 or 11 for a word (lane ignored). A read returns the selected part zero-extended to 32 bits.
- R6: A write changes only the addressed bytes, taking its data from the low bits of the write data.
- R7: Reads are combinational, and a write becomes visible in the cycle after its clock edge. A read of a byte that is being written in the same cycle returns the old value.
- R8: A status write loads all 16 bits at the next edge. A register write in the same cycle uses the bank that was current before that edge.
- R9: The fixed registers do not depend on the bank. The stack pointer output always shows fixed register 3, and it changes only through a write.
- R10: A flag swap exchanges status bits [7:0] with the shadow flag byte. A status write in the same cycle wins: the status word is loaded and the shadow byte is kept.
- R11: An accumulator swap exchanges byte 0 of register 0 of the current bank with the shadow accumulator byte and leaves the register's upper bytes alone. The write port is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_code | input | 8 | Register code, read port 0 |
| rd0_ext | input | 1 | 1 = extended code, 0 = 3-bit code, read port 0 |
| rd0_size | input | 2 | Access size, read port 0 |
| rd0_data | output | 32 | Zero-extended read data, port 0 |
| rd1_code | input | 8 | Register code, read port 1 |
| rd1_ext | input | 1 | Extended-code flag, read port 1 |
| rd1_size | input | 2 | Access size, read port 1 |
| rd1_data | output | 32 | Zero-extended read data, port 1 |
| wr_en | input | 1 | Register write enable |
| wr_code | input | 8 | Register code for the write |
| wr_ext | input | 1 | Extended-code flag for the write |
| wr_size | input | 2 | Access size for the write |
| wr_data | input | 32 | Write data, right-aligned |
| sr_wr_en | input | 1 | Status word load enable |
| sr_wr_data | input | 16 | New status word |
| swap_f | input | 1 | Exchange flag byte with its shadow |
| swap_a | input | 1 | Exchange accumulator byte with its shadow |
| sr_out | output | 16 | Current status word |
| sp_value | output | 32 | Stack pointer (fixed register 3) |

## Verification
The assertions check these rules on every cycle:
- a status load arrives intact;
- a flag swap exchanges both bytes, and the shadow flag byte holds in every other case;
- the shadow accumulator captures the old accumulator byte;
- byte and half reads carry zeros above their width;
- the stack pointer holds when no write occurs.

The bench scenarios cover what no single-cycle property can show. They sweep every extended code and every size across all four banks, so the code decoding, the wrap from bank 0 to bank 3 and the sub-word merge are all compared against a bench-side model. They also show three timing rules: a read sees the old value during a write, a same-cycle write lands in the bank that was current before the edge, and the write port is suppressed during an accumulator swap.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int WORD_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int LANES       = WORD_W / BYTE_W;
    localparam int LANE_W      = $clog2(LANES);
    localparam int BANKS       = 4;
    localparam int BANK_REGS   = 4;
    localparam int FIXED_REGS  = 4;
    localparam int BANK_W      = $clog2(BANKS);
    localparam int REG_W       = $clog2(BANK_REGS);
    localparam int BANKED_REGS = BANKS * BANK_REGS;
    localparam int TOTAL_REGS  = BANKED_REGS + FIXED_REGS;
    localparam int IDX_W       = $clog2(TOTAL_REGS);
    localparam int SP_IDX      = BANKED_REGS + FIXED_REGS - 1;
    localparam int RD_PORTS    = 2;

    localparam int CODE_W       = 8;
    localparam int SHORT_W      = 3;
    localparam int EXT_MODE_LSB = 6;
    localparam int EXT_BANK_LSB = 4;
    localparam int EXT_REG_LSB  = 2;

    localparam int SR_W     = 16;
    localparam int BANK_LSB = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        BM_CURRENT  = 2'b00,
        BM_PREVIOUS = 2'b01,
        BM_EXPLICIT = 2'b10,
        BM_FIXED    = 2'b11
    } bank_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] lane;
        size_e             size;
    } reg_sel_t;

    // Lane of the lowest byte actually touched for the given size.
    function automatic logic [LANE_W-1:0] norm_lane(size_e sz, logic [LANE_W-1:0] lane);
        logic [LANE_W-1:0] r;
        case (sz)
            SZ_BYTE: r = lane;
            SZ_HALF: r = {lane[LANE_W-1], {(LANE_W-1){1'b0}}};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [LANES-1:0] lane_enable(size_e sz, logic [LANE_W-1:0] lane);
        logic [LANES-1:0] r;
        case (sz)
            SZ_BYTE: r = LANES'(1) << lane;
            SZ_HALF: r = LANES'(3) << lane;
            default: r = '1;
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] size_mask(size_e sz);
        logic [WORD_W-1:0] r;
        case (sz)
            SZ_BYTE: r = WORD_W'({BYTE_W{1'b1}});
            SZ_HALF: r = WORD_W'({(2*BYTE_W){1'b1}});
            default: r = '1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
    import bankreg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              ext,
    input  logic [1:0]        size,
    input  logic [BANK_W-1:0] cur_bank,
    output reg_sel_t          sel
);

    bank_mode_e        mode;
    logic [BANK_W-1:0] bank;
    logic [REG_W-1:0]  rnum;
    logic [LANE_W-1:0] raw_lane;
    logic              fixed_set;
    size_e             sz;

    always_comb begin
        mode = bank_mode_e'(code[EXT_MODE_LSB +: 2]);
        sz   = size_e'(size);
        if (!ext) begin
            fixed_set = code[SHORT_W-1];
            rnum      = code[REG_W-1:0];
            raw_lane  = '0;
            bank      = cur_bank;
        end else begin
            fixed_set = (mode == BM_FIXED);
            rnum      = code[EXT_REG_LSB +: REG_W];
            raw_lane  = code[LANE_W-1:0];
            unique case (mode)
                BM_CURRENT:  bank = cur_bank;
                BM_PREVIOUS: bank = cur_bank - BANK_W'(1);
                BM_EXPLICIT: bank = code[EXT_BANK_LSB +: BANK_W];
                default:     bank = cur_bank;
            endcase
        end
        sel.size = sz;
        sel.lane = norm_lane(sz, raw_lane);
        if (fixed_set)
            sel.idx = IDX_W'(BANKED_REGS) + IDX_W'(rnum);
        else
            sel.idx = IDX_W'({bank, rnum});
    end

endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              swap_f,
    output logic [SR_W-1:0]   sr_q,
    output logic [BYTE_W-1:0] alt_f_q,
    output logic [BANK_W-1:0] cur_bank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            alt_f_q <= '0;
        end else if (sr_wr_en) begin
            sr_q <= sr_wr_data;
        end else if (swap_f) begin
            sr_q[BYTE_W-1:0] <= alt_f_q;
            alt_f_q          <= sr_q[BYTE_W-1:0];
        end
    end

    assign cur_bank = sr_q[BANK_LSB +: BANK_W];

endmodule

// File: rtl/bankreg_array.sv
module bankreg_array
    import bankreg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [IDX_W-1:0]                 w_idx,
    input  logic [LANES-1:0]                 w_be,
    input  logic [WORD_W-1:0]                w_word,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]   rd_idx,
    input  logic [IDX_W-1:0]                 acc_idx,
    output logic [RD_PORTS-1:0][WORD_W-1:0]  rd_word,
    output logic [BYTE_W-1:0]                acc_byte,
    output logic [WORD_W-1:0]                sp_word
);

    logic [TOTAL_REGS-1:0][WORD_W-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (we && (int'(w_idx) < TOTAL_REGS)) begin
            for (int l = 0; l < LANES; l++) begin
                if (w_be[l])
                    store_q[w_idx][l*BYTE_W +: BYTE_W] <= w_word[l*BYTE_W +: BYTE_W];
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rd_word[p] = store_q[rd_idx[p]];
    end

    assign acc_byte = store_q[acc_idx][BYTE_W-1:0];
    assign sp_word  = store_q[SP_IDX];

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rd0_code,
    input  logic              rd0_ext,
    input  logic [1:0]        rd0_size,
    output logic [WORD_W-1:0] rd0_data,
    input  logic [CODE_W-1:0] rd1_code,
    input  logic              rd1_ext,
    input  logic [1:0]        rd1_size,
    output logic [WORD_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_ext,
    input  logic [1:0]        wr_size,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sr_wr_en,
    input  logic [SR_W-1:0]   sr_wr_data,
    input  logic              swap_f,
    input  logic              swap_a,
    output logic [SR_W-1:0]   sr_out,
    output logic [WORD_W-1:0] sp_value
);

    localparam int ACC_REG = 0;

    logic [BANK_W-1:0] cur_bank;
    logic [BYTE_W-1:0] alt_f_q;
    logic [BYTE_W-1:0] alt_a_q;
    logic [BYTE_W-1:0] acc_byte;
    logic [IDX_W-1:0]  acc_idx;

    logic [RD_PORTS-1:0][CODE_W-1:0] rd_code;
    logic [RD_PORTS-1:0]             rd_ext;
    logic [RD_PORTS-1:0][1:0]        rd_size;
    reg_sel_t [RD_PORTS-1:0]         rd_sel;
    logic [RD_PORTS-1:0][IDX_W-1:0]  rd_idx;
    logic [RD_PORTS-1:0][WORD_W-1:0] rd_word;
    logic [RD_PORTS-1:0][WORD_W-1:0] rd_result;

    reg_sel_t          w_sel;
    logic              arr_we;
    logic [IDX_W-1:0]  arr_idx;
    logic [LANES-1:0]  arr_be;
    logic [WORD_W-1:0] arr_word;

    bankreg_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_wr_en   (sr_wr_en),
        .sr_wr_data (sr_wr_data),
        .swap_f     (swap_f),
        .sr_q       (sr_out),
        .alt_f_q    (alt_f_q),
        .cur_bank   (cur_bank)
    );

    assign rd_code = {rd1_code, rd0_code};
    assign rd_ext  = {rd1_ext, rd0_ext};
    assign rd_size = {rd1_size, rd0_size};

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd_port
        bankreg_decode u_dec (
            .code     (rd_code[p]),
            .ext      (rd_ext[p]),
            .size     (rd_size[p]),
            .cur_bank (cur_bank),
            .sel      (rd_sel[p])
        );
        assign rd_idx[p]    = rd_sel[p].idx;
        assign rd_result[p] = (rd_word[p] >> (BYTE_W * rd_sel[p].lane))
                              & size_mask(rd_sel[p].size);
    end

    assign rd0_data = rd_result[0];
    assign rd1_data = rd_result[1];

    bankreg_decode u_wr_dec (
        .code     (wr_code),
        .ext      (wr_ext),
        .size     (wr_size),
        .cur_bank (cur_bank),
        .sel      (w_sel)
    );

    assign acc_idx = IDX_W'({cur_bank, REG_W'(ACC_REG)});

    // The accumulator swap owns the single write path for its cycle.
    always_comb begin
        if (swap_a) begin
            arr_we   = 1'b1;
            arr_idx  = acc_idx;
            arr_be   = LANES'(1);
            arr_word = WORD_W'(alt_a_q);
        end else begin
            arr_we   = wr_en;
            arr_idx  = w_sel.idx;
            arr_be   = lane_enable(w_sel.size, w_sel.lane);
            arr_word = wr_data << (BYTE_W * w_sel.lane);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alt_a_q <= '0;
        else if (swap_a)
            alt_a_q <= acc_byte;
    end

    bankreg_array u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (arr_we),
        .w_idx    (arr_idx),
        .w_be     (arr_be),
        .w_word   (arr_word),
        .rd_idx   (rd_idx),
        .acc_idx  (acc_idx),
        .rd_word  (rd_word),
        .acc_byte (acc_byte),
        .sp_word  (sp_value)
    );

endmodule

// File: rtl/bankreg_checker.sv
module bankreg_checker
    import bankreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              sr_wr_en,
    input logic [SR_W-1:0]   sr_wr_data,
    input logic              swap_f,
    input logic              swap_a,
    input logic [SR_W-1:0]   sr_out,
    input logic [WORD_W-1:0] sp_value,
    input logic [1:0]        rd0_size,
    input logic [WORD_W-1:0] rd0_data,
    input logic [1:0]        rd1_size,
    input logic [WORD_W-1:0] rd1_data,
    input logic [BYTE_W-1:0] alt_f_q,
    input logic [BYTE_W-1:0] alt_a_q,
    input logic [BYTE_W-1:0] acc_byte
);

    assert_sr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en |=> sr_out == $past(sr_wr_data));

    assert_flag_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_f && !sr_wr_en) |=> (sr_out[BYTE_W-1:0] == $past(alt_f_q))
                                  && (alt_f_q == $past(sr_out[BYTE_W-1:0])));

    assert_altf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_f || sr_wr_en) |=> $stable(alt_f_q));

    assert_acc_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        swap_a |=> alt_a_q == $past(acc_byte));

    assert_alta_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_a |=> $stable(alt_a_q));

    assert_zext_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_size == 2'b00) |-> (rd0_data[WORD_W-1:BYTE_W] == '0));

    assert_zext_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_size == 2'b01) |-> (rd1_data[WORD_W-1:2*BYTE_W] == '0));

    assert_sp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sp_value));

endmodule

bind bankreg_file bankreg_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .swap_f     (swap_f),
    .swap_a     (swap_a),
    .sr_out     (sr_out),
    .sp_value   (sp_value),
    .rd0_size   (rd0_size),
    .rd0_data   (rd0_data),
    .rd1_size   (rd1_size),
    .rd1_data   (rd1_data),
    .alt_f_q    (alt_f_q),
    .alt_a_q    (alt_a_q),
    .acc_byte   (acc_byte)
);

// File: tb/bankreg_file_bench.sv
module bankreg_file_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]  rd0_code = '0, rd1_code = '0, wr_code = '0;
    logic        rd0_ext = 1'b0, rd1_ext = 1'b0, wr_ext = 1'b0;
    logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0, sp_value;
    logic        wr_en = 1'b0, sr_wr_en = 1'b0, swap_f = 1'b0, swap_a = 1'b0;
    logic [15:0] sr_wr_data = '0, sr_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] model [20];
    logic [15:0] m_sr;
    logic [7:0]  m_altf;
    logic [7:0]  m_alta;

    bankreg_file u_bankreg_file (
        .clk(clk), .rst_n(rst_n),
        .rd0_code(rd0_code), .rd0_ext(rd0_ext), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_code(rd1_code), .rd1_ext(rd1_ext), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_code(wr_code), .wr_ext(wr_ext), .wr_size(wr_size), .wr_data(wr_data),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .swap_f(swap_f), .swap_a(swap_a),
        .sr_out(sr_out), .sp_value(sp_value)
    );

    function automatic int m_idx(logic [7:0] code, logic ext);
        int cur;
        cur = int'(m_sr[9:8]);
        if (!ext) return code[2] ? 16 + int'(code[1:0]) : cur * 4 + int'(code[1:0]);
        case (code[7:6])
            2'b00:   return cur * 4 + int'(code[3:2]);
            2'b01:   return ((cur + 3) % 4) * 4 + int'(code[3:2]);
            2'b10:   return int'(code[5:4]) * 4 + int'(code[3:2]);
            default: return 16 + int'(code[3:2]);
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] code, logic ext, logic [1:0] sz);
        logic [31:0] w;
        logic [1:0]  ln;
        w  = model[m_idx(code, ext)];
        ln = ext ? code[1:0] : 2'b00;
        case (sz)
            2'b00:   return (w >> (8 * ln)) & 32'h0000_00FF;
            2'b01:   return (w >> (16 * ln[1])) & 32'h0000_FFFF;
            default: return w;
        endcase
    endfunction

    function automatic void m_write(logic [7:0] code, logic ext, logic [1:0] sz, logic [31:0] d);
        int i;
        int ln;
        i  = m_idx(code, ext);
        ln = ext ? int'(code[1:0]) : 0;
        case (sz)
            2'b00:   model[i][8*ln +: 8] = d[7:0];
            2'b01:   model[i][16*(ln/2) +: 16] = d[15:0];
            default: model[i] = d;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] code, input logic ext, input logic [1:0] sz,
                            input logic [31:0] d);
        wr_code = code; wr_ext = ext; wr_size = sz; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        m_write(code, ext, sz, d);
        wr_en = 1'b0;
    endtask

    task automatic set_sr(input logic [15:0] v);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(posedge clk); #1;
        m_sr = v;
        sr_wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] old0, old1;
        logic [7:0]  old_acc;
        for (int i = 0; i < 20; i++) model[i] = '0;
        m_sr = '0; m_altf = '0; m_alta = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 status after reset", 32'(sr_out), 32'h0);
        check("R1 stack pointer after reset", sp_value, 32'h0);
        for (int c = 0; c < 8; c++) begin
            rd0_code = 8'(c); rd0_ext = 1'b0; rd0_size = 2'b10; #1;
            check("R1 register after reset", rd0_data, 32'h0);
        end

        // Fill every banked register through the short code, fixed ones through mode 11
        for (int b = 0; b < 4; b++) begin
            set_sr(16'(b << 8));
            for (int r = 0; r < 4; r++)
                do_write(8'(r), 1'b0, 2'b10, (32'h0103_0507 * (b * 4 + r + 1)) ^ 32'h8000_0000);
        end
        for (int r = 0; r < 4; r++)
            do_write({2'b11, 2'b00, 2'(r), 2'b00}, 1'b1, 2'b10, 32'hF0E1_D2C3 + r * 32'h1111_1111);

        // Sweep every extended code and size in every bank (R2 R3 R4 R5 R9)
        for (int b = 0; b < 4; b++) begin
            set_sr(16'(b << 8) | 16'h0042);
            check("R8 status word loaded", 32'(sr_out), 32'(m_sr));
            check("R9 stack pointer is fixed register 3", sp_value, model[19]);
            for (int c = 0; c < 256; c++) begin
                for (int s = 0; s < 3; s++) begin
                    rd0_code = 8'(c); rd0_ext = 1'b1; rd0_size = 2'(s);
                    rd1_code = 8'(c); rd1_ext = 1'b0; rd1_size = 2'(s);
                    #1;
                    check((c / 64 == 1) ? $sformatf("R4 previous-bank read code %h size %0d", c, s)
                                        : $sformatf("R3 R5 extended read code %h size %0d", c, s),
                          rd0_data, m_read(8'(c), 1'b1, 2'(s)));
                    check($sformatf("R2 short read code %0d size %0d", c % 8, s),
                          rd1_data, m_read(8'(c), 1'b0, 2'(s)));
                end
            end
        end

        // R6 sub-word merges
        set_sr(16'h0200);
        for (int c = 0; c < 256; c++) begin
            for (int s = 0; s < 2; s++) begin
                do_write(8'(c), 1'b1, 2'(s), {~8'(c), 8'(c), 8'(c) ^ 8'h3C, 8'(c + s)});
                rd0_code = 8'(c); rd0_ext = 1'b1; rd0_size = 2'b10; #1;
                check($sformatf("R6 merge code %h size %0d", c, s), rd0_data, model[m_idx(8'(c), 1'b1)]);
            end
        end

        // R7 read during write returns old data
        rd0_code = 8'h84; rd0_ext = 1'b1; rd0_size = 2'b10;
        rd1_code = 8'h85; rd1_ext = 1'b1; rd1_size = 2'b00;
        old0 = model[1];
        wr_code = 8'h84; wr_ext = 1'b1; wr_size = 2'b10; wr_data = 32'h7777_1234; wr_en = 1'b1;
        #1;
        check("R7 read during write sees old word", rd0_data, old0);
        check("R7 second port old byte", rd1_data, (old0 >> 8) & 32'hFF);
        @(posedge clk); #1;
        m_write(8'h84, 1'b1, 2'b10, 32'h7777_1234);
        wr_en = 1'b0; #1;
        check("R7 write visible next cycle", rd0_data, 32'h7777_1234);
        check("R7 second port new byte", rd1_data, 32'h12);

        // R8 same-cycle status and register write: old bank (2) is used
        sr_wr_en = 1'b1; sr_wr_data = 16'h0100;
        wr_code = 8'd1; wr_ext = 1'b0; wr_size = 2'b10; wr_data = 32'hB0B0_0001; wr_en = 1'b1;
        @(posedge clk); #1;
        m_write(8'd1, 1'b0, 2'b10, 32'hB0B0_0001);
        m_sr = 16'h0100;
        sr_wr_en = 1'b0; wr_en = 1'b0;
        rd0_code = 8'hA4; rd0_ext = 1'b1; rd0_size = 2'b10;
        rd1_code = 8'd1;  rd1_ext = 1'b0; rd1_size = 2'b10;
        #1;
        check("R8 write lands in bank current before edge", rd0_data, 32'hB0B0_0001);
        check("R8 new bank seen after edge", rd1_data, model[5]);

        // R4 previous bank wraps from 0 to 3
        set_sr(16'h0000);
        rd0_code = 8'h48; rd0_ext = 1'b1; rd0_size = 2'b10; #1;
        check("R4 previous of bank 0 is bank 3", rd0_data, model[14]);

        // R10 flag swap
        set_sr(16'h02A5);
        check("R10 status loaded", 32'(sr_out), 32'h02A5);
        swap_f = 1'b1; @(posedge clk); #1; swap_f = 1'b0;
        m_altf = 8'hA5; m_sr = 16'h0200;
        check("R10 flag byte takes shadow", 32'(sr_out), 32'h0200);
        rd0_code = 8'd0; rd0_ext = 1'b0; rd0_size = 2'b10; #1;
        check("R10 swap keeps bank", rd0_data, model[8]);
        sr_wr_en = 1'b1; sr_wr_data = 16'h013C; swap_f = 1'b1;
        @(posedge clk); #1; sr_wr_en = 1'b0; swap_f = 1'b0;
        m_sr = 16'h013C;
        check("R10 status write beats swap", 32'(sr_out), 32'h013C);
        swap_f = 1'b1; @(posedge clk); #1; swap_f = 1'b0;
        check("R10 shadow kept over status write", 32'(sr_out), 32'h01A5);
        swap_f = 1'b1; @(posedge clk); #1; swap_f = 1'b0;
        check("R10 second swap restores", 32'(sr_out), 32'h013C);
        m_sr = 16'h013C; m_altf = 8'hA5;

        // R11 accumulator swap, bank 1, write port ignored
        old_acc = model[4][7:0];
        old1    = model[17];
        swap_a = 1'b1;
        wr_code = 8'd5; wr_ext = 1'b0; wr_size = 2'b10; wr_data = 32'hDEAD_BEEF; wr_en = 1'b1;
        @(posedge clk); #1;
        swap_a = 1'b0; wr_en = 1'b0;
        model[4][7:0] = m_alta; m_alta = old_acc;
        rd0_code = 8'd0; rd0_ext = 1'b0; rd0_size = 2'b10;
        rd1_code = 8'd5; rd1_ext = 1'b0; rd1_size = 2'b10;
        #1;
        check("R11 accumulator byte takes shadow, upper bytes kept", rd0_data, model[4]);
        check("R11 write port ignored during swap", rd1_data, old1);
        swap_a = 1'b1; @(posedge clk); #1; swap_a = 1'b0;
        model[4][7:0] = m_alta;
        rd0_size = 2'b00; #1;
        check("R11 second swap restores accumulator", rd0_data, 32'(old_acc));
        check("R9 stack pointer unchanged by swaps", sp_value, model[19]);

        finish_run();
    end

endmodule